// File: doc/BRIEF.md
# Dual-Address-Cycle Address Selector

This block supplies the high half of 64-bit bus addresses for a scripted bus-master engine and turns each access request into one or two address phases. It keeps six 32-bit high-address registers. Five are static and change only when software writes them through a small write port. The sixth is dynamic and is reloaded by the engine before each 64-bit direct block move.

Each request carries an operation type, a bus command, a 32-bit low address and a byte count. The operation type picks one of the high-address registers. If the chosen register is zero, the block puts out a single address phase. If it is nonzero, the block puts out a dual address cycle: first the low dword with the dual-address command, then the high dword with the real command. While it does so, the block also reports whether the requested span runs past a 4 GB boundary.

Requests use a valid/ready handshake. A new request is refused until the current address sequence has finished.

Top module: `dac_addr_sel`

## Requirements
- R1: After a synchronous active-low reset, every high-address register is zero, `req_ready` is 1 and `adr_valid` is 0, so any request gives a single address phase.
- R2: `req_op` values 0 to 4 select the static register with the same index. Value 5 selects the dynamic register. Values 6 and 7 select no register and always give a single address phase.
- R3: When the selected register is nonzero, two phases follow on consecutive cycles. The first has `adr_cbe`=4'hD, `adr_ad`=low address and `adr_last`=0. The second has `adr_cbe`=request command, `adr_ad`=register value and `adr_last`=1.
- R4: When the selected register is zero, one phase is produced, with `adr_cbe`=request command, `adr_ad`=low address and `adr_last`=1.
- R5: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. Its first phase is visible (`adr_valid`=1) in the next cycle.
- R6: `req_ready` is 0 whenever `adr_valid` is 1. It returns to 1 in the cycle after the last phase. A request held while not ready is not accepted.
- R7: A write with `cfg_we`=1 and `cfg_idx` 0 to 4 loads `cfg_wdata` into that static register. Writes with `cfg_idx` 5 to 7 change no register.
- R8: `dyn_ld`=1 loads `dyn_data` into the dynamic register. Static writes never alter the dynamic register, and `dyn_ld` never alters a static one.
- R9: During every phase of a request, `span_err` is 1 exactly when low address plus byte count exceeds 2^32. A byte count of zero never flags.
- R10: The high dword is the selected register's value at the acceptance edge. Writes after acceptance do not change the phases of the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Static register write strobe |
| cfg_idx | input | 3 | Static register index |
| cfg_wdata | input | 32 | Static register write data |
| dyn_ld | input | 1 | Dynamic register load strobe |
| dyn_data | input | 32 | Dynamic register load data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_op | input | 3 | Operation type (register select) |
| req_cmd | input | 4 | Bus command for the access |
| req_addr | input | 32 | Low 32 bits of the address |
| req_len | input | LEN_W (24) | Byte count of the operation |
| adr_valid | output | 1 | An address phase is on the outputs |
| adr_cbe | output | 4 | Command for this phase |
| adr_ad | output | 32 | Address dword for this phase |
| adr_last | output | 1 | This is the final phase of the sequence |
| span_err | output | 1 | Request span exceeds the 4 GB boundary |

## Verification
The assertions assume that `req_cmd` is never the dual-address code 4'hD. Under that assumption, a phase carrying any other command must be a final phase, and a non-final phase must carry 4'hD. The stimulus therefore replaces 4'hD with another code whenever it draws a random command. The span check is computed from the address and length captured at acceptance. It relies on `req_len` being narrower than the address, and the parameters keep it so. The stimulus pushes addresses up against the top of the 4 GB range, so both sides of the boundary are exercised.

// File: rtl/dac_sel_pkg.sv
// Package: shared constants and types for the dual-address-cycle selector.
// Assumes a 4-bit bus command field and a 3-bit operation type.
package dac_sel_pkg;
    localparam int OP_W  = 3;
    localparam int CMD_W = 4;
    localparam logic [CMD_W-1:0] DAC_CMD = 4'hD;

    // Operation types; index equals the static register it uses, 5 is dynamic.
    typedef enum logic [OP_W-1:0] {
        OP_TBL_MOVE = 3'd0,
        OP_IND_MOVE = 3'd1,
        OP_MEM_MOVE = 3'd2,
        OP_LDST     = 3'd3,
        OP_JUMP     = 3'd4,
        OP_DIR_MOVE = 3'd5
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAC  = 2'd1,
        ST_DAC1 = 2'd2,
        ST_DAC2 = 2'd3
    } phase_st_e;
endpackage

// File: rtl/dac_sel_bank.sv
// Module: bank of high-address registers and the operation-type select mux.
// Holds NUM_STATIC software-written registers plus one dynamic register.
// Assumes the dynamic register is addressed by op value NUM_STATIC.
module dac_sel_bank
    import dac_sel_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_STATIC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OP_W-1:0]   cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dyn_ld,
    input  logic [ADDR_W-1:0] dyn_data,
    input  logic [OP_W-1:0]   op,
    output logic [ADDR_W-1:0] sel_hi
);
    localparam logic [OP_W-1:0] DYN_OP = OP_W'(NUM_STATIC);

    logic [ADDR_W-1:0] stat_q [NUM_STATIC];
    logic [ADDR_W-1:0] dyn_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_STATIC; gi++) begin : g_stat
            // Load one static register when its index is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stat_q[gi] <= '0;
                else if (cfg_we && (cfg_idx == OP_W'(gi)))
                    stat_q[gi] <= cfg_wdata;
            end
        end
    endgenerate

    // Load the dynamic register from its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dyn_q <= '0;
        else if (dyn_ld)
            dyn_q <= dyn_data;
    end

    // Pick the register for the requested operation; unmapped ops give zero.
    always_comb begin
        sel_hi = '0;
        if (op == DYN_OP)
            sel_hi = dyn_q;
        else
            for (int k = 0; k < NUM_STATIC; k++)
                if (op == OP_W'(k))
                    sel_hi = stat_q[k];
    end
endmodule

// File: rtl/dac_span_chk.sv
// Module: flags an operation whose byte span goes past the top of the
// 32-bit address space. Assumes LEN_W < ADDR_W.
module dac_span_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              over
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] end_excl;

    // End address (exclusive) beyond 2^ADDR_W means the span wraps.
    always_comb begin
        end_excl = {1'b0, addr} + SUM_W'(len);
        over     = end_excl[ADDR_W] && (end_excl[ADDR_W-1:0] != '0);
    end
endmodule

// File: rtl/dac_phase_fsm.sv
// Module: accepts one request at a time and sequences its address phases.
// Assumes sel_hi and span_in are valid in the cycle the request is accepted.
module dac_phase_fsm
    import dac_sel_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] sel_hi,
    input  logic              span_in,
    output logic              adr_valid,
    output logic [CMD_W-1:0]  adr_cbe,
    output logic [ADDR_W-1:0] adr_ad,
    output logic              adr_last,
    output logic              span_err
);
    phase_st_e         st_q, st_d;
    logic [CMD_W-1:0]  cmd_q;
    logic [ADDR_W-1:0] lo_q, hi_q;
    logic              err_q;
    logic              take;

    assign take = req_valid && (st_q == ST_IDLE);

    // Next-state choice: a nonzero high dword needs the two-phase path.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (req_valid) st_d = (sel_hi != '0) ? ST_DAC1 : ST_SAC;
            ST_SAC:  st_d = ST_IDLE;
            ST_DAC1: st_d = ST_DAC2;
            ST_DAC2: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Snapshot the request and its high dword at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            err_q <= 1'b0;
        end else if (take) begin
            cmd_q <= req_cmd;
            lo_q  <= req_addr;
            hi_q  <= sel_hi;
            err_q <= span_in;
        end
    end

    // Drive the phase outputs from the current state.
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        adr_valid = (st_q != ST_IDLE);
        adr_cbe   = (st_q == ST_DAC1) ? DAC_CMD : cmd_q;
        adr_ad    = (st_q == ST_DAC2) ? hi_q : lo_q;
        adr_last  = (st_q == ST_SAC) || (st_q == ST_DAC2);
        span_err  = adr_valid && err_q;
    end
endmodule

// File: rtl/dac_addr_sel.sv
// Module: top of the dual-address-cycle selector. Joins the register bank,
// the span check and the phase sequencer. Assumes req_cmd is never 4'hD.
module dac_addr_sel
    import dac_sel_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 24,
    parameter int NUM_STATIC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dyn_ld,
    input  logic [ADDR_W-1:0] dyn_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              adr_valid,
    output logic [3:0]        adr_cbe,
    output logic [ADDR_W-1:0] adr_ad,
    output logic              adr_last,
    output logic              span_err
);
    logic [ADDR_W-1:0] sel_hi;
    logic              span_over;

    dac_sel_bank #(.ADDR_W(ADDR_W), .NUM_STATIC(NUM_STATIC)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .dyn_ld(dyn_ld), .dyn_data(dyn_data),
        .op(req_op), .sel_hi(sel_hi)
    );

    dac_span_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) span_i (
        .addr(req_addr), .len(req_len), .over(span_over)
    );

    dac_phase_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr),
        .sel_hi(sel_hi), .span_in(span_over),
        .adr_valid(adr_valid), .adr_cbe(adr_cbe), .adr_ad(adr_ad),
        .adr_last(adr_last), .span_err(span_err)
    );
endmodule

// File: rtl/dac_addr_sel_chk.sv
// Checker: temporal properties of the selector's handshake and phases.
// Assumes req_cmd never equals the dual-address code.
module dac_addr_sel_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_len,
    input logic              adr_valid,
    input logic [3:0]        adr_cbe,
    input logic              adr_last,
    input logic              span_err
);
    localparam int SUM_W = ADDR_W + 1;
    localparam logic [SUM_W-1:0] TOP = {1'b1, {ADDR_W{1'b0}}};

    logic [ADDR_W-1:0] a_cap;
    logic [LEN_W-1:0]  l_cap;

    // Capture the accepted request for the span property.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cap <= '0;
            l_cap <= '0;
        end else if (req_valid && req_ready) begin
            a_cap <= req_addr;
            l_cap <= req_len;
        end
    end

    // R5
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> adr_valid);
    // R6
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adr_valid |-> !req_ready);
    // R6
    free_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adr_valid && adr_last |=> !adr_valid && req_ready);
    // R3
    dac_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adr_valid && !adr_last |=> adr_valid && adr_last);
    // R3
    dac_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adr_valid && !adr_last |-> adr_cbe == 4'hD);
    // R4
    sac_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adr_valid && adr_cbe != 4'hD |-> adr_last);
    // R9
    span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adr_valid |-> span_err == (({1'b0, a_cap} + SUM_W'(l_cap)) > TOP));
    // R9
    span_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adr_valid && !adr_last |=> $stable(span_err));
endmodule

bind dac_addr_sel dac_addr_sel_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .adr_valid(adr_valid),
    .adr_cbe(adr_cbe), .adr_last(adr_last), .span_err(span_err)
);

// File: tb/dac_addr_sel_tb_top.sv
// Bench: behavioural queue model of the address phases, compared each cycle.
module dac_addr_sel_tb_top;
    localparam int LEN_W = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        dyn_ld = 1'b0;
    logic [31:0] dyn_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [3:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic        adr_valid;
    logic [3:0]  adr_cbe;
    logic [31:0] adr_ad;
    logic        adr_last;
    logic        span_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dac_addr_sel #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .dyn_ld(dyn_ld), .dyn_data(dyn_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .adr_valid(adr_valid), .adr_cbe(adr_cbe), .adr_ad(adr_ad),
        .adr_last(adr_last), .span_err(span_err)
    );

    typedef struct packed {
        logic [3:0]  cbe;
        logic [31:0] ad;
        logic        last;
        logic        err;
    } ph_t;

    ph_t         exp_q[$];
    logic [31:0] m_stat [5];
    logic [31:0] m_dyn;

    task automatic chk(input bit ok, input string tag,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pick_hi(input logic [2:0] op);
        if (op == 3'd5) return m_dyn;
        if (op < 3'd5)  return m_stat[op];
        return 32'h0;
    endfunction

    // Reference model: advances on every clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            for (int i = 0; i < 5; i++) m_stat[i] = '0;
            m_dyn = '0;
        end else begin
            bit          acc;
            logic [31:0] hi;
            logic        er;
            acc = req_valid && (exp_q.size() == 0);
            if (exp_q.size() != 0) void'(exp_q.pop_front());
            if (acc) begin
                hi = pick_hi(req_op);
                er = (64'(req_addr) + 64'(req_len)) > 64'h1_0000_0000;
                if (hi != 0) begin
                    exp_q.push_back('{4'hD, req_addr, 1'b0, er});
                    exp_q.push_back('{req_cmd, hi, 1'b1, er});
                end else
                    exp_q.push_back('{req_cmd, req_addr, 1'b1, er});
            end
            if (cfg_we && cfg_idx < 3'd5) m_stat[cfg_idx] = cfg_wdata;
            if (dyn_ld) m_dyn = dyn_data;
        end
    end

    // Compare the outputs with the model in the middle of each cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(req_ready == (exp_q.size() == 0), "R6 req_ready",
                req_ready, exp_q.size() == 0);
            chk(adr_valid == (exp_q.size() != 0), "R5 adr_valid",
                adr_valid, exp_q.size() != 0);
            if (adr_valid && exp_q.size() != 0) begin
                chk(adr_cbe == exp_q[0].cbe, "R3/R4 adr_cbe", adr_cbe, exp_q[0].cbe);
                chk(adr_ad == exp_q[0].ad, "R2/R7/R8/R10 adr_ad", adr_ad, exp_q[0].ad);
                chk(adr_last == exp_q[0].last, "R3/R4 adr_last", adr_last, exp_q[0].last);
                chk(span_err == exp_q[0].err, "R9 span_err", span_err, exp_q[0].err);
            end
        end
    end

    task automatic send(input logic [2:0] op, input logic [3:0] cmd,
                        input logic [31:0] a, input logic [LEN_W-1:0] n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        #1;
        req_valid = 1'b1; req_op = op; req_cmd = cmd; req_addr = a; req_len = n;
        @(negedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic wr_stat(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        #1;
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic ld_dyn(input logic [31:0] d);
        @(negedge clk);
        #1;
        dyn_ld = 1'b1; dyn_data = d;
        @(negedge clk);
        #1;
        dyn_ld = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(adr_valid == 1'b0, "R1 no phase after reset", adr_valid, 0);
        // R1: every op gives one phase while registers are zero
        for (int op = 0; op < 8; op++) send(3'(op), 4'h6, 32'h1000 + 32'(op), 24'd4);
        drain();

        // R7: load static registers, index 2 left zero, junk to 5..7
        wr_stat(3'd0, 32'hA000_0001);
        wr_stat(3'd1, 32'hA000_0002);
        wr_stat(3'd3, 32'hA000_0004);
        wr_stat(3'd4, 32'hA000_0005);
        wr_stat(3'd5, 32'hDEAD_0005);
        wr_stat(3'd6, 32'hDEAD_0006);
        wr_stat(3'd7, 32'hDEAD_0007);
        // R2 R8: dynamic still zero, ops 6/7 single phase
        for (int op = 0; op < 8; op++) send(3'(op), 4'h7, 32'h2000 + 32'(op), 24'd8);
        drain();
        ld_dyn(32'h0000_00FF);
        for (int op = 0; op < 8; op++) send(3'(op), 4'hC, 32'h3000 + 32'(op), 24'd8);
        drain();

        // R9: boundary spans
        send(3'd0, 4'h6, 32'hFFFF_FFF0, 24'd16);
        send(3'd0, 4'h6, 32'hFFFF_FFF0, 24'd17);
        send(3'd2, 4'h7, 32'hFFFF_FFFF, 24'd0);
        send(3'd2, 4'h7, 32'hFFFF_FFFF, 24'd1);
        send(3'd2, 4'h7, 32'hFFFF_FFFF, 24'd2);
        send(3'd1, 4'h6, 32'h0, 24'hFF_FFFF);
        drain();

        // R10: writes right after acceptance
        fork
            send(3'd5, 4'h6, 32'h4000, 24'd4);
            begin @(negedge clk); #1; dyn_ld = 1'b1; dyn_data = 32'h1111_2222;
                  @(negedge clk); #1; dyn_ld = 1'b0; end
        join
        fork
            send(3'd0, 4'h7, 32'h5000, 24'd4);
            begin @(negedge clk); @(negedge clk); #1; cfg_we = 1'b1; cfg_idx = 3'd0;
                  cfg_wdata = 32'h0; @(negedge clk); #1; cfg_we = 1'b0; end
        join
        drain();
        send(3'd0, 4'h7, 32'h5100, 24'd4);
        drain();

        // R6 R7 R8: random traffic with requests held while busy
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            req_valid = ($urandom_range(0, 3) != 0);
            req_op    = 3'($urandom_range(0, 7));
            req_cmd   = 4'($urandom_range(0, 15));
            if (req_cmd == 4'hD) req_cmd = 4'h7;
            req_addr  = ($urandom_range(0, 1) != 0) ? (32'hFFFF_FF00 | 32'($urandom_range(0, 255)))
                                                    : $urandom;
            req_len   = 24'($urandom_range(0, 511));
            cfg_we    = ($urandom_range(0, 7) == 0);
            cfg_idx   = 3'($urandom_range(0, 7));
            cfg_wdata = ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom;
            dyn_ld    = ($urandom_range(0, 7) == 0);
            dyn_data  = ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom;
        end
        @(negedge clk);
        #1;
        req_valid = 1'b0; cfg_we = 1'b0; dyn_ld = 1'b0;
        drain();

        // R1: reset clears all registers again
        @(negedge clk); #1 rst_n = 1'b0;
        @(negedge clk); @(negedge clk); #1 rst_n = 1'b1;
        for (int op = 0; op < 6; op++) send(3'(op), 4'h6, 32'h6000, 24'd4);
        drain();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule